// File: doc/BRIEF.md
# Sensorless Spindle Start and Brake Controller

This block sequences a three-phase sensorless spindle motor through start-up, running and stopping. A six-step commutation index selects, for each of the three motor legs, whether the leg is pulled high, pulled low or left floating. After a start request, the index either advances open-loop on a fixed energization period, or follows the validated zero-crossing pulses from the back-EMF detector. In external mode it follows a software-driven step strobe instead.

A stop request brakes the motor. When a reverse brake is requested with a non-zero duration, the controller first walks the commutation index backwards for that time. It then falls back to dynamic braking with all low-side switches on. A watchdog counts milliseconds without a valid zero crossing. When it expires, the stuck-rotor flag is raised and the motor is braked. A coast input floats every leg, whatever the controller is doing.

Top module: `spindle_start_ctrl`

## Requirements
- R1: While the start input is 0 and no reverse brake is running, the controller brakes dynamically. The phase is 0, all three low-side outputs are 1, all high-side outputs are 0, braking is 1 and the stuck flag is 0. This is also the state after reset.
- R2: In a driven step p (0..5), the high-side leg is p/2 and the low-side leg is (p/2 + 1 + p mod 2) mod 3. The remaining leg floats. Bit 0 of each leg vector is leg A, bit 1 is leg B and bit 2 is leg C.
- R3: The first cycle after the start input is seen high (from braking), the phase is 0. In internal open-loop mode, the phase then advances by one (5 wraps to 0) every (energize_sel+1)*10 ms ticks.
- R4: In internal mode, an unmasked zero-crossing pulse advances the phase by one on the next clock edge and switches to closed loop. In closed loop, the energization timer no longer steps the phase.
- R5: After every forward step, zero-crossing pulses are ignored for MASK_UNIT_CYC*2^mask_sel clock cycles. A pulse sampled k edges after the step is ignored for k up to that length and accepted at one more.
- R6: In external mode, each 0-to-1 transition of the step strobe advances the phase by one. A strobe held high gives no further steps. Zero crossings and the energization timer do not move the phase.
- R7: If no valid zero crossing arrives within 400 ms (stuck_sel=0) or 100 ms (stuck_sel=1) of start or of the last valid one, the stuck flag is raised and the motor brakes dynamically. This lasts until the start input goes to 0, which clears the flag.
- R8: With coast at 1, all high-side and low-side outputs are 0, while the phase keeps being tracked.
- R9: Start falling with reverse brake requested and rev_time_sel 1, 2 or 3 gives 10, 20 or 40 ms of reverse braking. During that time braking is 1, the step pattern is driven, and the phase goes back by one (0 wraps to 5) on every ms tick. The controller then enters dynamic braking at phase 0.
- R10: Start falling with no reverse request, or with rev_time_sel 0, enters dynamic braking on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| start_i | input | 1 | 1 runs the motor, 0 stops and brakes it |
| ext_mode_i | input | 1 | 1 steps from the strobe, 0 steps internally |
| step_strobe_i | input | 1 | External step strobe, rising edge counts |
| coast_i | input | 1 | Floats all legs |
| rev_brake_i | input | 1 | Requests reverse braking on stop |
| rev_time_sel_i | input | 2 | Reverse-brake length code (0 none, 1/2/3 = 10/20/40 ms) |
| energize_sel_i | input | 2 | Open-loop step period code, (code+1)*10 ms |
| stuck_sel_i | input | 1 | Stuck timeout, 0 = 400 ms, 1 = 100 ms |
| mask_sel_i | input | 2 | Zero-crossing mask length, unit*2^code cycles |
| zc_pulse_i | input | 1 | Zero-crossing pulse from the back-EMF detector |
| phase_o | output | 3 | Commutation step 0..5 |
| hs_on_o | output | 3 | High-side enable per leg (bit 0 = A) |
| ls_on_o | output | 3 | Low-side enable per leg (bit 0 = A) |
| braking_o | output | 1 | Motor is being braked |
| stuck_rotor_o | output | 1 | Stuck-rotor timeout has occurred |

## Verification
Every input acts on registered state, so a strobe, zero crossing or start change is visible one clock edge after it is sampled. Leg outputs and coast are combinational on that state. A timer expiry costs one more edge: the count reaches its limit on the tick edge and the step happens on the next edge. The bench drives each millisecond as a tick followed by three idle cycles. It samples on falling edges after that second edge. One tick before each limit it checks that nothing has changed yet. For masking, it places one-cycle pulses exactly at the last masked edge and at the first open edge.

// File: rtl/spin_seq_pkg.sv
package spin_seq_pkg;
  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned NUM_LEGS  = 3;

  typedef logic [2:0] step_t;

  typedef enum logic [2:0] {
    ST_BRAKE  = 3'd0,
    ST_REVBRK = 3'd1,
    ST_OPEN   = 3'd2,
    ST_CLOSED = 3'd3,
    ST_STUCK  = 3'd4
  } ctl_state_e;

  typedef enum logic [1:0] {
    DRV_STEP  = 2'd0,
    DRV_LOWS  = 2'd1,
    DRV_FLOAT = 2'd2
  } drv_mode_e;

  function automatic step_t step_next(step_t s);
    return (s == step_t'(NUM_STEPS - 1)) ? step_t'(0) : step_t'(s + 3'd1);
  endfunction

  function automatic step_t step_prev(step_t s);
    return (s == step_t'(0)) ? step_t'(NUM_STEPS - 1) : step_t'(s - 3'd1);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/spin_ms_window.sv
module spin_ms_window #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt_q <= '0;
    else if (clear_i)                              cnt_q <= '0;
    else if (run_i && tick_i && cnt_q != limit_i)  cnt_q <= cnt_q + W'(1);
  end

  assign expired_o = run_i && (cnt_q == limit_i);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/spin_zc_mask.sv
module spin_zc_mask #(
  parameter int unsigned UNIT_CYC = 20000,
  localparam int unsigned MW = $clog2((UNIT_CYC << 3) + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       flush_i,
  input  logic [1:0] sel_i,
  output logic       open_o
);
  logic [MW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= MW'(UNIT_CYC) << sel_i;
    else if (flush_i)       cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - MW'(1);
  end

  assign open_o = (cnt_q == '0);

  // R5
  mask_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !load_i) |=> open_o);
endmodule

// File: rtl/spin_drive_map.sv
module spin_drive_map
  import spin_seq_pkg::*;
(
  input  step_t                 step_i,
  input  drv_mode_e             mode_i,
  output logic [NUM_LEGS-1:0]   hs_o,
  output logic [NUM_LEGS-1:0]   ls_o
);
  logic [1:0] hi_idx;
  logic [2:0] lo_sum;
  logic [1:0] lo_idx;

  always_comb begin
    hi_idx = step_i[2:1];
    lo_sum = {1'b0, hi_idx} + 3'd1 + {2'b00, step_i[0]};
    lo_idx = (lo_sum >= 3'd3) ? 2'(lo_sum - 3'd3) : lo_sum[1:0];
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign hs_o[g] = (mode_i == DRV_STEP) && (hi_idx == 2'(g));
    assign ls_o[g] = (mode_i == DRV_LOWS) ||
                     ((mode_i == DRV_STEP) && (lo_idx == 2'(g)));
  end
endmodule

// File: rtl/spindle_start_ctrl.sv
module spindle_start_ctrl
  import spin_seq_pkg::*;
#(
  parameter int unsigned ENERGIZE_STEP_MS = 10,
  parameter int unsigned STUCK_LONG_MS    = 400,
  parameter int unsigned STUCK_SHORT_MS   = 100,
  parameter int unsigned REV_STEP_MS      = 10,
  parameter int unsigned MASK_UNIT_CYC    = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick_i,
  input  logic       start_i,
  input  logic       ext_mode_i,
  input  logic       step_strobe_i,
  input  logic       coast_i,
  input  logic       rev_brake_i,
  input  logic [1:0] rev_time_sel_i,
  input  logic [1:0] energize_sel_i,
  input  logic       stuck_sel_i,
  input  logic [1:0] mask_sel_i,
  input  logic       zc_pulse_i,
  output logic [2:0] phase_o,
  output logic [2:0] hs_on_o,
  output logic [2:0] ls_on_o,
  output logic       braking_o,
  output logic       stuck_rotor_o
);
  localparam int unsigned LIM_MAX = max3(4 * ENERGIZE_STEP_MS, STUCK_LONG_MS, 4 * REV_STEP_MS);
  localparam int unsigned TW      = $clog2(LIM_MAX + 1);

  ctl_state_e state_q, state_d;
  step_t      phase_q, phase_d;
  logic       strobe_q;

  logic spinning, strobe_rise, zc_valid, open_step, adv, rb_ok;
  logic mask_open, energize_exp, stuck_exp, rev_exp;
  logic [TW-1:0] energize_lim, stuck_lim, rev_lim;
  drv_mode_e drv_mode;

  // limits from the selection codes
  always_comb begin
    energize_lim = TW'((int'(energize_sel_i) + 1) * ENERGIZE_STEP_MS);
    stuck_lim    = stuck_sel_i ? TW'(STUCK_SHORT_MS) : TW'(STUCK_LONG_MS);
    case (rev_time_sel_i)
      2'd1:    rev_lim = TW'(REV_STEP_MS);
      2'd2:    rev_lim = TW'(2 * REV_STEP_MS);
      default: rev_lim = TW'(4 * REV_STEP_MS);
    endcase
  end

  assign spinning    = (state_q == ST_OPEN) || (state_q == ST_CLOSED);
  assign strobe_rise = step_strobe_i && !strobe_q;
  assign zc_valid    = spinning && zc_pulse_i && mask_open;
  assign open_step   = (state_q == ST_OPEN) && !ext_mode_i && energize_exp;
  assign adv         = spinning && (ext_mode_i ? strobe_rise : (zc_valid || open_step));
  assign rb_ok       = rev_brake_i && (rev_time_sel_i != 2'd0);

  spin_ms_window #(.W(TW)) u_energize (
    .clk(clk), .rst_n(rst_n),
    .clear_i((state_q != ST_OPEN) || adv),
    .run_i((state_q == ST_OPEN) && !ext_mode_i),
    .tick_i(ms_tick_i), .limit_i(energize_lim), .expired_o(energize_exp));

  spin_ms_window #(.W(TW)) u_stuck (
    .clk(clk), .rst_n(rst_n),
    .clear_i(!spinning || zc_valid),
    .run_i(spinning),
    .tick_i(ms_tick_i), .limit_i(stuck_lim), .expired_o(stuck_exp));

  spin_ms_window #(.W(TW)) u_revbrk (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state_q != ST_REVBRK),
    .run_i(state_q == ST_REVBRK),
    .tick_i(ms_tick_i), .limit_i(rev_lim), .expired_o(rev_exp));

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BRAKE:  if (start_i) state_d = ST_OPEN;
      ST_OPEN, ST_CLOSED: begin
        if (!start_i)       state_d = rb_ok ? ST_REVBRK : ST_BRAKE;
        else if (stuck_exp) state_d = ST_STUCK;
        else if (zc_valid)  state_d = ST_CLOSED;
      end
      ST_REVBRK: begin
        if (start_i)        state_d = ST_OPEN;
        else if (rev_exp)   state_d = ST_BRAKE;
      end
      ST_STUCK:  if (!start_i) state_d = ST_BRAKE;
      default:   state_d = ST_BRAKE;
    endcase
  end

  // next phase
  always_comb begin
    phase_d = phase_q;
    if (state_d == ST_BRAKE)
      phase_d = '0;
    else if ((state_d == ST_OPEN) && !spinning)
      phase_d = '0;
    else if ((state_q == ST_REVBRK) && ms_tick_i)
      phase_d = step_prev(phase_q);
    else if (adv && ((state_d == ST_OPEN) || (state_d == ST_CLOSED)))
      phase_d = step_next(phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_BRAKE;
      phase_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      strobe_q <= step_strobe_i;
    end
  end

  spin_zc_mask #(.UNIT_CYC(MASK_UNIT_CYC)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .load_i(adv && ((state_d == ST_OPEN) || (state_d == ST_CLOSED))),
    .flush_i(!spinning),
    .sel_i(mask_sel_i), .open_o(mask_open));

  always_comb begin
    if (coast_i)                                         drv_mode = DRV_FLOAT;
    else if ((state_q == ST_BRAKE) || (state_q == ST_STUCK)) drv_mode = DRV_LOWS;
    else                                                 drv_mode = DRV_STEP;
  end

  spin_drive_map u_drive (
    .step_i(phase_q), .mode_i(drv_mode), .hs_o(hs_on_o), .ls_o(ls_on_o));

  assign phase_o       = phase_q;
  assign braking_o     = (state_q == ST_BRAKE) || (state_q == ST_REVBRK) || (state_q == ST_STUCK);
  assign stuck_rotor_o = (state_q == ST_STUCK);

  // R1
  start_low_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> braking_o);

  // R2
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_on_o & ls_on_o) == 3'b000) && $onehot0(hs_on_o));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o < 3'(NUM_STEPS));

  // R6
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |->
      (phase_q == step_next($past(phase_q))) || (phase_q == step_prev($past(phase_q))) ||
      (phase_q == 3'd0));

  // R5
  zc_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CLOSED) && start_i && !ext_mode_i && zc_pulse_i && !mask_open)
      |=> (phase_q == $past(phase_q)));

  // R7
  stuck_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_rotor_o |-> (braking_o && (coast_i || (ls_on_o == 3'b111))));

  // R8
  coast_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coast_i |-> ((hs_on_o == 3'b000) && (ls_on_o == 3'b000)));
endmodule

// File: tb/test_spindle_start_ctrl.sv
module test_spindle_start_ctrl;
  localparam int MASK_UNIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, start = 1'b0, ext_mode = 1'b0, strobe = 1'b0, coast = 1'b0;
  logic rev_brake = 1'b0, stuck_sel = 1'b0, zc = 1'b0;
  logic [1:0] rev_sel = 2'd0, energize_sel = 2'd0, mask_sel = 2'd0;
  logic [2:0] phase, hs, ls;
  logic braking, stuck;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  spindle_start_ctrl #(.MASK_UNIT_CYC(MASK_UNIT)) i_spindle_start_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .start_i(start),
    .ext_mode_i(ext_mode), .step_strobe_i(strobe), .coast_i(coast),
    .rev_brake_i(rev_brake), .rev_time_sel_i(rev_sel), .energize_sel_i(energize_sel),
    .stuck_sel_i(stuck_sel), .mask_sel_i(mask_sel), .zc_pulse_i(zc),
    .phase_o(phase), .hs_on_o(hs), .ls_on_o(ls), .braking_o(braking),
    .stuck_rotor_o(stuck));

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_drive(int p, string req);
    int hi, lo;
    hi = p / 2;
    lo = (hi + 1 + (p % 2)) % 3;
    chk({req, " phase"}, int'(phase), p);
    chk({req, " hs"}, int'(hs), 1 << hi);
    chk({req, " ls"}, int'(ls), 1 << lo);
  endtask

  task automatic check_brake(string req);
    chk({req, " braking"}, int'(braking), 1);
    chk({req, " phase"}, int'(phase), 0);
    chk({req, " hs"}, int'(hs), 0);
    chk({req, " ls"}, int'(ls), 7);
  endtask

  task automatic ms(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_after(int m);
    repeat (m) @(negedge clk);
    zc = 1'b1;
    @(negedge clk) zc = 1'b0;
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_stop();
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_step();
    strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_brake("R1");
    chk("R1 stuck", int'(stuck), 0);

    // R3 open-loop stepping for every energize code
    for (int es = 0; es < 4; es++) begin
      int len;
      energize_sel = 2'(es);
      len = (es + 1) * 10;
      do_start();
      check_drive(0, "R2");
      for (int s = 0; s < 7; s++) begin
        ms(len - 1);
        chk("R3 before", int'(phase), s % 6);
        ms(1);
        check_drive((s + 1) % 6, "R3");
      end
      do_stop();
      check_brake("R10");
    end

    // R4 closed loop stops energize stepping
    energize_sel = 2'd0;
    do_start();
    pulse_after(0);
    chk("R4 zc step", int'(phase), 1);
    ms(25);
    chk("R4 no open step", int'(phase), 1);
    pulse_after(70);
    chk("R4 zc step2", int'(phase), 2);
    do_stop();

    // R5 mask boundary for every mask code
    for (int msel = 0; msel < 4; msel++) begin
      int len;
      mask_sel = 2'(msel);
      len = MASK_UNIT << msel;
      do_start();
      pulse_after(0);
      chk("R5 first", int'(phase), 1);
      pulse_after(len - 1);
      chk("R5 masked", int'(phase), 1);
      pulse_after(0);
      chk("R5 open", int'(phase), 2);
      do_stop();
    end
    mask_sel = 2'd0;

    // R7 stuck watchdog, both timeouts, restarted by a zero crossing
    for (int ss = 0; ss < 2; ss++) begin
      int lim;
      stuck_sel = ss[0];
      lim = ss ? 100 : 400;
      energize_sel = 2'd3;
      do_start();
      pulse_after(0);
      ms(lim - 5);
      pulse_after(0);
      chk("R7 restart", int'(phase), 2);
      ms(lim - 1);
      chk("R7 not yet", int'(stuck), 0);
      ms(1);
      chk("R7 stuck", int'(stuck), 1);
      chk("R7 braking", int'(braking), 1);
      chk("R7 ls", int'(ls), 7);
      chk("R7 hs", int'(hs), 0);
      ms(3);
      chk("R7 held", int'(stuck), 1);
      do_stop();
      chk("R7 cleared", int'(stuck), 0);
      check_brake("R1");
    end
    // R7 open loop without any zero crossing
    stuck_sel = 1'b1;
    do_start();
    ms(99);
    chk("R7 open not yet", int'(stuck), 0);
    ms(1);
    chk("R7 open stuck", int'(stuck), 1);
    do_stop();
    stuck_sel = 1'b0;

    // R6 external stepping
    ext_mode = 1'b1;
    energize_sel = 2'd0;
    do_start();
    ms(15);
    chk("R6 no open step", int'(phase), 0);
    for (int k = 1; k <= 7; k++) begin
      strobe = 1'b1;
      @(negedge clk);
      check_drive(k % 6, "R6");
      repeat (3) @(negedge clk);
      chk("R6 held strobe", int'(phase), k % 6);
      pulse_after(70);
      chk("R6 zc ignored", int'(phase), k % 6);
      strobe = 1'b0;
      @(negedge clk);
    end

    // R8 coast
    coast = 1'b1;
    @(negedge clk);
    chk("R8 hs", int'(hs), 0);
    chk("R8 ls", int'(ls), 0);
    strobe_step();
    chk("R8 phase tracked", int'(phase), 2);
    chk("R8 hs step", int'(hs), 0);
    coast = 1'b0;
    @(negedge clk);
    check_drive(2, "R8");
    do_stop();
    coast = 1'b1;
    @(negedge clk);
    chk("R8 brake ls", int'(ls), 0);
    coast = 1'b0;

    // R9 reverse brake for each duration
    for (int rs = 1; rs < 4; rs++) begin
      int d, p;
      d = (rs == 1) ? 10 : (rs == 2) ? 20 : 40;
      rev_sel = 2'(rs);
      rev_brake = 1'b0;
      do_start();
      strobe_step();
      strobe_step();
      strobe_step();
      chk("R9 setup", int'(phase), 3);
      rev_brake = 1'b1;
      do_stop();
      chk("R9 braking", int'(braking), 1);
      check_drive(3, "R9 entry");
      ms(d - 1);
      p = (((3 - (d - 1)) % 6) + 6) % 6;
      check_drive(p, "R9 walk");
      chk("R9 braking walk", int'(braking), 1);
      ms(1);
      check_brake("R9 end");
    end

    // R10 no reverse when code is 0 or request is 0
    rev_brake = 1'b1;
    rev_sel = 2'd0;
    do_start();
    strobe_step();
    do_stop();
    check_brake("R10 code0");
    rev_brake = 1'b0;
    rev_sel = 2'd2;
    do_start();
    strobe_step();
    do_stop();
    check_brake("R10 noreq");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule